// File: doc/BRIEF.md
# Atomic Execution Placement Predictor

This block decides where each atomic memory request should run: in the requesting core's private L1 cache, or at a shared cache level further out. A block that one CPU keeps hitting over and over is worth pulling into that CPU's L1. A block that several CPUs pass between them is better handled at the shared level, so that the line does not move back and forth between cores.

The predictor keeps a small direct-mapped table indexed by the low bits of the cache-block address. Each slot holds a valid bit, an address tag, the ID of the CPU that touched the block last, and a saturating run counter. A request arrives as a valid pulse with a block address and a CPU ID. The decision (local or shared) is registered and comes out on the next cycle. The table slot is rewritten on the same clock edge, so a request in the following cycle already sees the update.

Conceptually, each slot is in one of three states. VACANT means the slot holds no block. WARMING means a block is present with run count ≤ LIMIT. SETTLED means run count > LIMIT. Each valid request is classed as one of the following:

- MISS: the slot is vacant or the tag differs. The slot goes to WARMING, owned by the requester, with count 1.
- SWITCH: the tag matches but a different CPU is asking. The slot goes to WARMING, the owner is replaced, and the count restarts at 1.
- REPEAT: the tag matches and the same CPU is asking. The count increments, and the slot moves WARMING→SETTLED once it exceeds LIMIT.

Only a REPEAT access that leaves the count above LIMIT is placed locally.

Top module: `atomic_place_predictor`

## Requirements
- R1: After reset, dec_valid and dec_local are 0 and every table slot is vacant, so the first request to any block is placed at the shared level (dec_local=0).
- R2: dec_valid is 1 exactly in the cycle after a cycle with req_valid=1; a decision appears one cycle after its request.
- R3: A request whose slot (index = req_addr[3:0]) is vacant or holds a different tag (tag = req_addr[31:4]) is a MISS. It is placed shared (dec_local=0), and it allocates the slot for the requesting CPU with run count 1.
- R4: A request from the CPU that last touched the same block increments that block's run count. It is placed locally (dec_local=1) only when the new count exceeds LIMIT (default 3), so the fourth consecutive access by one CPU after allocation is the first local one.
- R5: A request to a tracked block from a CPU other than its last user is placed shared. The new CPU becomes the owner with run count 1, so it needs LIMIT further repeats before it is placed locally.
- R6: The run count is 3 bits wide and saturates at 7. A long run by one CPU keeps being placed locally, and a switch after saturation still restarts the count at 1.
- R7: The table is direct-mapped with 16 slots. Two blocks with the same index evict each other, while blocks with different indices are tracked independently, even when their requests are interleaved.
- R8: A cycle with req_valid=0 changes no slot and produces dec_valid=0 and dec_local=0 in the following cycle.
- R9: Back-to-back requests to the same block in consecutive cycles see each other's updates with no lost increments.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Atomic request present this cycle |
| req_addr | input | ADDR_W (32) | Cache-block address of the request |
| req_cpu | input | CPU_W (3) | ID of the requesting CPU |
| dec_valid | output | 1 | Decision valid (request of previous cycle) |
| dec_local | output | 1 | 1 = run in requester's L1, 0 = run at shared level |

## Verification
Every decision is due exactly one clock after the cycle in which its request was presented, and the table update is due on that same edge. The driver task therefore presents one request per falling edge and pushes its expected placement into a queue. The monitor samples on every falling edge, pops one item whenever dec_valid is high, and flags any decision that turns up with nothing queued. Idle stretches are checked at the falling edge that follows a full idle cycle, and the queue must be empty two cycles after the last request.

// File: rtl/apred_pkg.sv
package apred_pkg;

    // Classification of one valid access against its table slot
    typedef enum logic [1:0] {
        CLS_MISS   = 2'd0,
        CLS_SWITCH = 2'd1,
        CLS_REPEAT = 2'd2
    } access_cls_e;

endpackage

// File: rtl/apred_addr_split.sv
module apred_addr_split #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic [ADDR_W-1:0] blk_addr,
    output logic [IDX_W-1:0]  slot_idx,
    output logic [TAG_W-1:0]  slot_tag
);

    always_comb begin
        slot_idx = blk_addr[IDX_W-1:0];
        slot_tag = blk_addr[ADDR_W-1:IDX_W];
    end

endmodule

// File: rtl/apred_table.sv
module apred_table #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 28,
    parameter int CPU_W = 3,
    parameter int CNT_W = 3,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    // read port (combinational)
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_used,
    output logic [TAG_W-1:0] rd_tag,
    output logic [CPU_W-1:0] rd_cpu,
    output logic [CNT_W-1:0] rd_cnt,
    // write port
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [CPU_W-1:0] wr_cpu,
    input  logic [CNT_W-1:0] wr_cnt
);

    logic             used_q [ENTRIES];
    logic [TAG_W-1:0] tag_q  [ENTRIES];
    logic [CPU_W-1:0] cpu_q  [ENTRIES];
    logic [CNT_W-1:0] cnt_q  [ENTRIES];
    logic [ENTRIES-1:0] wr_sel;

    // per-slot write decode
    for (genvar e = 0; e < ENTRIES; e++) begin : g_sel
        assign wr_sel[e] = wr_en && (wr_idx == IDX_W'(e));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                used_q[e] <= 1'b0;
                tag_q[e]  <= '0;
                cpu_q[e]  <= '0;
                cnt_q[e]  <= '0;
            end
        end else begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (wr_sel[e]) begin
                    used_q[e] <= 1'b1;
                    tag_q[e]  <= wr_tag;
                    cpu_q[e]  <= wr_cpu;
                    cnt_q[e]  <= wr_cnt;
                end
            end
        end
    end

    always_comb begin
        rd_used = used_q[rd_idx];
        rd_tag  = tag_q[rd_idx];
        rd_cpu  = cpu_q[rd_idx];
        rd_cnt  = cnt_q[rd_idx];
    end

endmodule

// File: rtl/apred_decide.sv
module apred_decide
    import apred_pkg::*;
#(
    parameter int TAG_W = 28,
    parameter int CPU_W = 3,
    parameter int CNT_W = 3,
    parameter int LIMIT = 3,
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}}
) (
    input  logic             slot_used,
    input  logic [TAG_W-1:0] slot_tag,
    input  logic [CPU_W-1:0] slot_cpu,
    input  logic [CNT_W-1:0] slot_cnt,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [CPU_W-1:0] req_cpu,
    output access_cls_e      cls,
    output logic [CNT_W-1:0] next_cnt,
    output logic             go_local
);

    logic tag_hit;
    logic same_cpu;

    always_comb begin
        tag_hit  = slot_used && (slot_tag == req_tag);
        same_cpu = (slot_cpu == req_cpu);
        if (!tag_hit)      cls = CLS_MISS;
        else if (same_cpu) cls = CLS_REPEAT;
        else               cls = CLS_SWITCH;
    end

    always_comb begin
        next_cnt = {{(CNT_W-1){1'b0}}, 1'b1};
        go_local = 1'b0;
        unique case (cls)
            CLS_MISS: begin
                next_cnt = {{(CNT_W-1){1'b0}}, 1'b1};
                go_local = 1'b0;
            end
            CLS_SWITCH: begin
                next_cnt = {{(CNT_W-1){1'b0}}, 1'b1};
                go_local = 1'b0;
            end
            CLS_REPEAT: begin
                next_cnt = (slot_cnt == CNT_MAX) ? slot_cnt : slot_cnt + 1'b1;
                go_local = (int'(next_cnt) > LIMIT);
            end
            default: begin
                next_cnt = {{(CNT_W-1){1'b0}}, 1'b1};
                go_local = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/atomic_place_predictor.sv
module atomic_place_predictor
    import apred_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CPU_W  = 3,
    parameter int IDX_W  = 4,
    parameter int CNT_W  = 3,
    parameter int LIMIT  = 3,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CPU_W-1:0]  req_cpu,
    output logic              dec_valid,
    output logic              dec_local
);

    logic [IDX_W-1:0] req_idx;
    logic [TAG_W-1:0] req_tag;
    logic             slot_used;
    logic [TAG_W-1:0] slot_tag;
    logic [CPU_W-1:0] slot_cpu;
    logic [CNT_W-1:0] slot_cnt;
    access_cls_e      acc_cls;
    logic [CNT_W-1:0] next_cnt;
    logic             go_local;

    apred_addr_split #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) split_i (
        .blk_addr (req_addr),
        .slot_idx (req_idx),
        .slot_tag (req_tag)
    );

    apred_table #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .CPU_W (CPU_W),
        .CNT_W (CNT_W)
    ) table_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (req_idx),
        .rd_used (slot_used),
        .rd_tag  (slot_tag),
        .rd_cpu  (slot_cpu),
        .rd_cnt  (slot_cnt),
        .wr_en   (req_valid),
        .wr_idx  (req_idx),
        .wr_tag  (req_tag),
        .wr_cpu  (req_cpu),
        .wr_cnt  (next_cnt)
    );

    apred_decide #(
        .TAG_W (TAG_W),
        .CPU_W (CPU_W),
        .CNT_W (CNT_W),
        .LIMIT (LIMIT)
    ) decide_i (
        .slot_used (slot_used),
        .slot_tag  (slot_tag),
        .slot_cpu  (slot_cpu),
        .slot_cnt  (slot_cnt),
        .req_tag   (req_tag),
        .req_cpu   (req_cpu),
        .cls       (acc_cls),
        .next_cnt  (next_cnt),
        .go_local  (go_local)
    );

    // registered decision, same edge as the table write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            dec_local <= 1'b0;
        end else begin
            dec_valid <= req_valid;
            dec_local <= req_valid && go_local;
        end
    end

endmodule

// File: rtl/apred_checker.sv
module apred_checker
    import apred_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CPU_W  = 3,
    parameter int LIMIT  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [CPU_W-1:0]  req_cpu,
    input logic              dec_valid,
    input logic              dec_local,
    input access_cls_e       acc_cls
);

    logic              prev_valid;
    logic [ADDR_W-1:0] prev_addr;
    logic [CPU_W-1:0]  prev_cpu;
    logic [7:0]        run_q;

    // length of the current back-to-back run of identical requests
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_valid <= 1'b0;
            prev_addr  <= '0;
            prev_cpu   <= '0;
            run_q      <= '0;
        end else begin
            prev_valid <= req_valid;
            prev_addr  <= req_addr;
            prev_cpu   <= req_cpu;
            if (!req_valid)
                run_q <= '0;
            else if (prev_valid && prev_addr == req_addr && prev_cpu == req_cpu)
                run_q <= (run_q == 8'hFF) ? run_q : run_q + 8'd1;
            else
                run_q <= 8'd1;
        end
    end

    AST_VALID_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> dec_valid); // R2

    AST_IDLE_NO_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!dec_valid && !dec_local)); // R8

    AST_NONREPEAT_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_cls != CLS_REPEAT) |=> !dec_local); // R3

    AST_SWITCH_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && prev_valid && req_addr == prev_addr && req_cpu != prev_cpu)
        |=> !dec_local); // R5

    AST_RUN_GOES_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && int'(run_q) > LIMIT) |-> dec_local); // R4

endmodule

bind atomic_place_predictor apred_checker #(
    .ADDR_W (ADDR_W),
    .CPU_W  (CPU_W),
    .LIMIT  (LIMIT)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_cpu   (req_cpu),
    .dec_valid (dec_valid),
    .dec_local (dec_local),
    .acc_cls   (acc_cls)
);

// File: tb/atomic_place_predictor_tb_top.sv
module atomic_place_predictor_tb_top;

    localparam int ADDR_W = 32;
    localparam int CPU_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [CPU_W-1:0]  req_cpu = '0;
    logic              dec_valid;
    logic              dec_local;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    bit    exp_q [$];
    string tag_q [$];

    always #10 clk = ~clk; // 50 MHz

    atomic_place_predictor dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_cpu   (req_cpu),
        .dec_valid (dec_valid),
        .dec_local (dec_local)
    );

    task automatic check(input string rq, input logic act, input logic exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0b expected=%0b", rq, what, act, exp);
        end
    endtask

    // driver: one request per falling edge, expectation queued
    task automatic send(input logic [ADDR_W-1:0] a, input logic [CPU_W-1:0] c,
                        input bit exp_loc, input string rq);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_cpu   = c;
        exp_q.push_back(exp_loc);
        tag_q.push_back(rq);
    endtask

    task automatic idle(input int n, input string rq);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_addr  = '1;
            req_cpu   = '1;
        end
        if (n >= 2) begin
            check(rq, dec_valid, 1'b0, "dec_valid after idle");
            check(rq, dec_local, 1'b0, "dec_local after idle");
        end
    endtask

    // monitor: decisions are due one cycle after their request
    always @(negedge clk) begin
        if (rst_n && dec_valid) begin
            if (exp_q.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL R2 unexpected decision: actual=1 expected=0");
            end else begin
                automatic bit    e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, dec_local, e, "dec_local");
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    localparam logic [31:0] BLK_A = 32'h0000_0100; // index 0
    localparam logic [31:0] BLK_B = 32'h0000_0210; // index 0, other tag
    localparam logic [31:0] BLK_C = 32'h0000_0101; // index 1

    initial begin
        repeat (3) @(negedge clk);
        check("R1", dec_valid, 1'b0, "dec_valid in reset");
        check("R1", dec_local, 1'b0, "dec_local in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", dec_valid, 1'b0, "dec_valid after reset");

        // R1/R3 first touch shared; R4 fourth run access local; R9 back-to-back
        send(BLK_A, 3'd2, 1'b0, "R1");
        send(BLK_A, 3'd2, 1'b0, "R4");
        send(BLK_A, 3'd2, 1'b0, "R4");
        send(BLK_A, 3'd2, 1'b1, "R4");
        // R6: long run past saturation stays local
        for (int i = 0; i < 10; i++) send(BLK_A, 3'd2, 1'b1, "R6");
        // R5/R6: switch after saturation restarts at 1
        send(BLK_A, 3'd5, 1'b0, "R5");
        send(BLK_A, 3'd5, 1'b0, "R6");
        send(BLK_A, 3'd5, 1'b0, "R6");
        send(BLK_A, 3'd5, 1'b1, "R5");
        // R8: idle cycles leave the slot untouched
        idle(3, "R8");
        send(BLK_A, 3'd5, 1'b1, "R8");
        idle(2, "R2");
        // R7: same index evicts
        send(BLK_B, 3'd5, 1'b0, "R7");
        send(BLK_A, 3'd5, 1'b0, "R7");
        // R7: interleaved independent indices
        send(BLK_C, 3'd1, 1'b0, "R7");
        send(BLK_A, 3'd5, 1'b0, "R7");
        send(BLK_C, 3'd1, 1'b0, "R7");
        send(BLK_A, 3'd5, 1'b0, "R7");
        send(BLK_C, 3'd1, 1'b0, "R7");
        send(BLK_A, 3'd5, 1'b1, "R7");
        send(BLK_C, 3'd1, 1'b1, "R7");
        // R3: miss allocates with count 1
        send(BLK_B, 3'd3, 1'b0, "R3");
        send(BLK_B, 3'd3, 1'b0, "R3");
        send(BLK_B, 3'd3, 1'b0, "R3");
        send(BLK_B, 3'd3, 1'b1, "R3");
        // R5: ping-pong between two CPUs never goes local
        send(BLK_C, 3'd4, 1'b0, "R5");
        send(BLK_C, 3'd1, 1'b0, "R5");
        send(BLK_C, 3'd4, 1'b0, "R5");
        send(BLK_C, 3'd1, 1'b0, "R5");
        idle(3, "R8");

        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2 pending decisions: actual=%0d expected=0", exp_q.size());
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule